// File: doc/BRIEF.md
# Line Decimator by Pixel Selection

This block shrinks a scanned image line to a narrower paper width by passing some pixels through unchanged and discarding the rest. No pixel value is ever combined or interpolated. A two-bit mode input picks the ratio: full width, 13 of 15, 9 of 11, or 12 of 17. Pixels arrive on a valid/data stream with a line-start marker and a frame-start marker. The output stream carries only the kept pixels. Its valid is low in every cycle whose input pixel was dropped or absent.

The keep decision comes from a running accumulator. Each accepted pixel adds the ratio numerator to it. When the sum reaches the denominator, the pixel is kept and the denominator is subtracted. A second accumulator of the same kind steps once per line and gives a line-keep flag, so a downstream consumer can apply the same reduction in the sub-scan direction.

A two-state controller governs the pixel path. `ST_IDLE` is the state after reset, before any line start has been seen. In it, every pixel is dropped. The transition `idle_to_line` fires on the first valid pixel that carries the line-start marker. `ST_LINE` then persists. Each further line start re-arms the accumulator through the transition `line_restart`, a self-loop on `ST_LINE`.

Top module: `line_decimator`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `out_sol` and `out_line_keep` are low.
- R2: Every output pixel is the input pixel accepted one clock earlier, with its data bits unchanged. `out_valid` rises in the cycle after the kept input pixel is accepted.
- R3: `mode_sel` encodes the ratio N/D as follows: 0 is 1/1, 1 is 13/15, 2 is 9/11 and 3 is 12/17. Number the pixels of a line from 1, starting with the pixel that carries the line start. Pixel i is kept exactly when floor(i*N/D) differs from floor((i-1)*N/D).
- R4: In every run of D consecutive pixels of a line, counted from the line start, exactly N pixels are kept.
- R5: A line start clears the pixel accumulator, even if the previous line ended part way through a period. Every line therefore follows the same keep pattern.
- R6: `mode_sel` is sampled only on the pixel that carries the line start. A change during a line affects nothing until the next line start.
- R7: Cycles with `in_valid` low do not advance the pattern and give `out_valid` low. `in_sol` and `in_sof` are ignored in such cycles.
- R8: After reset, pixels that arrive before the first line start are all dropped.
- R9: `out_sol` is high together with `out_valid` on the first kept pixel of each line, and low on all other kept pixels.
- R10: A line start with `in_sof` high begins a frame. It clears the line accumulator and samples `mode_sel` for the frame's line ratio. Line k of a frame, counted from 1, gets `out_line_keep` high on all its output pixels exactly when floor(k*N/D) differs from floor((k-1)*N/D). Before the first frame start, every line is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_sof | input | 1 | With `in_sol`, the line is the first of a frame |
| in_data | input | DATA_W | Input pixel value |
| mode_sel | input | 2 | Ratio select (0 full, 1 13/15, 2 9/11, 3 12/17) |
| out_valid | output | 1 | Kept pixel present |
| out_sol | output | 1 | First kept pixel of a line |
| out_line_keep | output | 1 | Current line is kept in the sub-scan direction |
| out_data | output | DATA_W | Kept pixel value |

## Verification
The bench drives each ratio over lines longer than one period, so that a wrong numerator, an off-by-one keep comparison or a misplaced subtraction shows up as a missing, extra or shifted pixel in the scoreboard. It changes `mode_sel` in the middle of a line. A design that reads the mode every pixel would switch patterns part way through the line. It ends a line before its period completes and starts another at once. A design that fails to clear the accumulator would then start the new line out of phase. Pixels sent before the first line start, and idle cycles carrying stray markers, are both expected to produce nothing. A frame started in 13/15 mode must drop its first line and keep the second.

// File: rtl/decim_pkg.sv
`timescale 1ns/1ps
package decim_pkg;

    // Ratio field width; must hold the largest denominator (17)
    localparam int RATIO_W = 5;

    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_13_15 = 2'd1,
        MODE_9_11  = 2'd2,
        MODE_12_17 = 2'd3
    } decim_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LINE = 1'b1
    } decim_state_t;

endpackage

// File: rtl/decim_ratio_sel.sv
`timescale 1ns/1ps
module decim_ratio_sel
    import decim_pkg::*;
#(
    parameter int W = RATIO_W
) (
    input  logic [1:0]   mode,
    output logic [W-1:0] num,
    output logic [W-1:0] den
);
    decim_mode_t m;

    always_comb begin
        m = decim_mode_t'(mode);
        unique case (m)
            MODE_FULL:  begin num = W'(1);  den = W'(1);  end
            MODE_13_15: begin num = W'(13); den = W'(15); end
            MODE_9_11:  begin num = W'(9);  den = W'(11); end
            MODE_12_17: begin num = W'(12); den = W'(17); end
            default:    begin num = W'(1);  den = W'(1);  end
        endcase
    end
endmodule

// File: rtl/decim_accum.sv
`timescale 1ns/1ps
module decim_accum #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clear,
    input  logic [W-1:0] num_new,
    input  logic [W-1:0] den_new,
    output logic         keep
);
    logic [W-1:0] num_q, den_q, acc_q;
    logic [W-1:0] num_u, den_u, base;
    logic [W:0]   sum, rem;

    // Ratio is taken on a clearing step and held until the next one
    always_comb begin
        num_u = clear ? num_new : num_q;
        den_u = clear ? den_new : den_q;
        base  = clear ? '0 : acc_q;
        sum   = {1'b0, base} + {1'b0, num_u};
        keep  = step && (sum >= {1'b0, den_u});
        rem   = keep ? (sum - {1'b0, den_u}) : sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            num_q <= W'(1);
            den_q <= W'(1);
            acc_q <= '0;
        end else if (step) begin
            if (clear) begin
                num_q <= num_new;
                den_q <= den_new;
            end
            acc_q <= rem[W-1:0];
        end
    end

    // Independent per-period keep counter guarding the accumulator
    logic [W:0] pcnt, kcnt, pc, kc, kdone_q;
    logic       done_q;

    always_comb begin
        pc = (clear ? '0 : pcnt) + (W+1)'(1);
        kc = (clear ? '0 : kcnt) + {{W{1'b0}}, keep};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt    <= '0;
            kcnt    <= '0;
            done_q  <= 1'b0;
            kdone_q <= '0;
        end else if (step) begin
            if (pc == {1'b0, den_u}) begin
                pcnt    <= '0;
                kcnt    <= '0;
                done_q  <= 1'b1;
                kdone_q <= kc;
            end else begin
                pcnt    <= pc;
                kcnt    <= kc;
                done_q  <= 1'b0;
            end
        end else begin
            done_q <= 1'b0;
        end
    end

    // R4
    per_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (kdone_q == {1'b0, num_q}));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < den_q);
endmodule

// File: rtl/line_decimator.sv
`timescale 1ns/1ps
module line_decimator
    import decim_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sol,
    input  logic              in_sof,
    input  logic [DATA_W-1:0] in_data,
    input  logic [1:0]        mode_sel,
    output logic              out_valid,
    output logic              out_sol,
    output logic              out_line_keep,
    output logic [DATA_W-1:0] out_data
);
    localparam int RW = RATIO_W;

    decim_state_t      state_q, state_d;
    logic              line_start, frame_start, pix_step;
    logic              pix_keep, line_keep_c, line_keep_q, line_keep_now;
    logic              first_pend_q;
    logic [RW-1:0]     sel_num, sel_den;

    assign line_start  = in_valid && in_sol;
    assign frame_start = line_start && in_sof;

    decim_ratio_sel #(.W(RW)) u_ratio (
        .mode (mode_sel),
        .num  (sel_num),
        .den  (sel_den)
    );

    // Controller: idle_to_line on first line start, line_restart afterwards
    always_comb begin
        state_d  = state_q;
        pix_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pix_step = line_start;
                if (line_start) state_d = ST_LINE;
            end
            ST_LINE: begin
                pix_step = in_valid;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    decim_accum #(.W(RW)) u_pix_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (pix_step),
        .clear   (line_start),
        .num_new (sel_num),
        .den_new (sel_den),
        .keep    (pix_keep)
    );

    decim_accum #(.W(RW)) u_line_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (line_start),
        .clear   (frame_start),
        .num_new (sel_num),
        .den_new (sel_den),
        .keep    (line_keep_c)
    );

    assign line_keep_now = line_start ? line_keep_c : line_keep_q;

    // Output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_sol       <= 1'b0;
            out_line_keep <= 1'b0;
            out_data      <= '0;
            line_keep_q   <= 1'b1;
            first_pend_q  <= 1'b0;
        end else begin
            out_valid <= pix_keep;
            out_sol   <= pix_keep && (line_start || first_pend_q);
            if (line_start) line_keep_q <= line_keep_c;
            if (pix_keep) begin
                out_data      <= in_data;
                out_line_keep <= line_keep_now;
                first_pend_q  <= 1'b0;
            end else begin
                out_line_keep <= 1'b0;
                if (line_start) first_pend_q <= 1'b1;
            end
        end
    end

    // R2
    data_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_data == $past(in_data)));

    // R7
    idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9
    sol_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    // R8
    presol_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !line_start) |=> !out_valid);
endmodule

// File: tb/sim_line_decimator.sv
`timescale 1ns/1ps
module sim_line_decimator;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [1:0]    mode_sel = 2'd0;
    logic          out_valid, out_sol, out_line_keep;
    logic [DW-1:0] out_data;

    always #4 clk = ~clk;

    line_decimator #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_sof(in_sof), .in_data(in_data), .mode_sel(mode_sel),
        .out_valid(out_valid), .out_sol(out_sol),
        .out_line_keep(out_line_keep), .out_data(out_data)
    );

    int checks = 0, errors = 0, out_cnt = 0;
    logic [DW+1:0] sb[$];   // {line_keep, sol, data}
    logic [DW-1:0] pix_ctr = 8'd1;
    int fnum = 1, fden = 1, lidx = 0;

    function automatic int rnum(input int m);
        return (m == 1) ? 13 : (m == 2) ? 9 : (m == 3) ? 12 : 1;
    endfunction
    function automatic int rden(input int m);
        return (m == 1) ? 15 : (m == 2) ? 11 : (m == 3) ? 17 : 1;
    endfunction
    function automatic bit kept(input int i, input int n, input int d);
        return ((i * n) / d) != (((i - 1) * n) / d);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            out_cnt++;
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected pixel", int'(out_data), -1);
            end else begin
                logic [DW+1:0] e;
                e = sb.pop_front();
                check(out_data == e[DW-1:0], "R2 data", int'(out_data), int'(e[DW-1:0]));
                check(out_sol == e[DW], "R9 sol", int'(out_sol), int'(e[DW]));
                check(out_line_keep == e[DW+1], "R10 line keep",
                      int'(out_line_keep), int'(e[DW+1]));
            end
        end
    end

    // One line; mode changes to chg_mode from pixel chg_at on (0: never)
    task automatic drive_line(input int mode, input int len, input bit sof,
                              input bit gaps, input int chg_at, input int chg_mode);
        bit first_done = 1'b0;
        bit lk;
        if (sof) begin
            fnum = rnum(mode);
            fden = rden(mode);
            lidx = 0;
        end
        lidx++;
        lk = kept(lidx, fnum, fden);
        for (int i = 1; i <= len; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1;
            in_sol   = (i == 1);
            in_sof   = (i == 1) && sof;
            in_data  = pix_ctr;
            mode_sel = (chg_at != 0 && i >= chg_at) ? 2'(chg_mode) : 2'(mode);
            if (kept(i, rnum(mode), rden(mode))) begin
                sb.push_back({lk, !first_done, pix_ctr});
                first_done = 1'b1;
            end
            pix_ctr++;
            if (gaps && (i % 3 == 0)) begin
                // R7: idle cycle with stray markers
                @(posedge clk); #1;
                in_valid = 1'b0; in_sol = 1'b1; in_sof = 1'b1; in_data = 8'hEE;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0; in_sol = 1'b0; in_sof = 1'b0;
    endtask

    task automatic drain_and_count(input int exp, input string req);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_cnt == exp, req, out_cnt, exp);
        check(sb.size() == 0, req, sb.size(), 0);
        out_cnt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!out_valid && !out_sol && !out_line_keep, "R1 in reset", int'(out_valid), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && !out_sol && !out_line_keep, "R1 after reset", int'(out_valid), 0);

        // R8: pixels before any line start are dropped
        for (int i = 0; i < 5; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b1; in_data = 8'h55; mode_sel = 2'd0;
        end
        @(posedge clk); #1 in_valid = 1'b0;
        drain_and_count(0, "R8 pre-line pixels");

        // R3 bypass, before any frame: line kept (R10)
        drive_line(0, 8, 1'b0, 1'b0, 0, 0);
        drain_and_count(8, "R3 bypass count");

        // R3/R4/R7/R10: frame in 13/15 with gaps; first line dropped in sub-scan
        drive_line(1, 30, 1'b1, 1'b1, 0, 0);
        drain_and_count(26, "R4 13/15 two periods");

        // R3/R4: 9/11, second line of frame is kept
        drive_line(2, 22, 1'b0, 1'b0, 0, 0);
        drain_and_count(18, "R4 9/11 two periods");

        // R3/R4: 12/17
        drive_line(3, 34, 1'b0, 1'b1, 0, 0);
        drain_and_count(24, "R4 12/17 two periods");

        // R6: mid-line switch from 9/11 to 12/17 must not affect this line
        drive_line(2, 22, 1'b0, 1'b0, 5, 3);
        drain_and_count(18, "R6 mid-line mode change");
        drive_line(3, 17, 1'b0, 1'b0, 0, 0);
        drain_and_count(12, "R6 new mode next line");

        // R5: short line then immediate restart, same pattern each time
        drive_line(1, 7, 1'b0, 1'b0, 0, 0);
        drive_line(1, 15, 1'b0, 1'b0, 0, 0);
        drain_and_count(6 + 13, "R5 restart after partial period");

        // R10: new frame in 12/17 drops its first line in sub-scan
        drive_line(3, 17, 1'b1, 1'b0, 0, 0);
        drain_and_count(12, "R10 new frame");

        finish_run();
    end
endmodule